// File: doc/BRIEF.md
# Configurable Serial CRC Engine

This block computes a cyclic redundancy check one message bit per clock. An n-bit remainder register is updated whenever a qualified data bit arrives. The incoming bit is combined with the register's highest-order coefficient at the moment that coefficient is tested. Because of this, the message never has to be padded with n trailing zeros. The highest-order coefficient of the generator is implicit and is never stored. Parameters set the register width, the generator constant, the shift direction, the preset value and the final inversion mask.

The same instance can generate a check value or verify one. To generate, feed the message, then read the inverted register on `crc_out`. To verify in one pass, feed the message followed by its check value in the matching bit order. `crc_pass` then reports whether the register has reached the residue. That residue is derived from the parameters at elaboration.

Top module: `crc_serial_engine`

## Requirements
- R1: With LSB_FIRST=0 the register shifts toward its top bit, and the feedback is the top bit XOR the input bit. A feedback of 1 XORs POLY into the shifted value. With POLY=0x07, width 8, zero preset and zero inversion, the byte 0x57 fed top bit first gives crc_out 0xA2.
- R2: With LSB_FIRST=1 the register shifts toward bit 0, and the feedback is bit 0 XOR the input bit. POLY is given in reflected form. With POLY=0xE0, width 8, zero preset and no inversion, 0x57 fed bit 0 first gives 0x19. With POLY=0x8408, width 16, preset 0xFFFF and inversion 0xFFFF, the ASCII string "123456789" fed bit 0 first in each byte gives 0x906E.
- R3: In a cycle with bit_vld, sop and clr all low, the register keeps its value, whatever bit_in carries.
- R4: sop loads PRESET. A valid bit in the same cycle is folded into PRESET rather than into the old contents, so starting in the middle of a message discards the earlier bits.
- R5: clr loads PRESET, discards any valid bit in that cycle and takes priority over sop.
- R6: After reset the register holds PRESET, so crc_out reads PRESET XOR XOR_OUT.
- R7: crc_out always equals the register XOR XOR_OUT.
- R8: After a correct message and its crc_out value have been fed in matching order, crc_pass is 1. In LSB_FIRST=0 mode the check value is sent top bit first; in LSB_FIRST=1 mode it is sent bit 0 first. With XOR_OUT=0 the residue is zero. For the 0x8408/0xFFFF/0xFFFF configuration, crc_out reads 0x0F47 at that point. A corrupted check value leaves crc_pass at 0.
- R9: With POLY=0x1021, width 16, preset 0xFFFF and no inversion, the ASCII string "123456789" fed top bit first in each byte gives 0x29B1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads PRESET |
| clr | input | 1 | Synchronous clear to PRESET, highest priority |
| sop | input | 1 | Start of message, loads PRESET |
| bit_vld | input | 1 | Qualifies bit_in |
| bit_in | input | 1 | Serial message bit |
| crc_out | output | WIDTH | Register XOR XOR_OUT |
| crc_pass | output | 1 | Register equals the one-pass residue |

## Verification
The assertions assume only that inputs are stable around the rising edge. They treat clr, sop and bit_vld as independent, so any combination of the three is legal. The stimulus drives every input just after a falling edge and returns it to zero after the next rising edge. This means an idle cycle is always a true hold, with or without a toggling bit_in. Random messages, mid-message restarts and a clear issued together with sop and a valid bit cover the priority cases the register assertions examine.

// File: rtl/crc_pkg.sv
package crc_pkg;

   localparam int unsigned MAX_WIDTH = 64;

   // Feeds the low w bits of pattern through a zero-started register in
   // transmission order. The result is the residue seen by a one-pass check.
   function automatic logic [MAX_WIDTH-1:0] crc_residue(
      input int unsigned          w,
      input logic [MAX_WIDTH-1:0] poly,
      input bit                   lsb,
      input logic [MAX_WIDTH-1:0] pattern
   );
      logic [MAX_WIDTH-1:0] st;
      logic [MAX_WIDTH-1:0] mask;
      logic                 b;
      logic                 fb;
      st   = '0;
      mask = (w >= MAX_WIDTH) ? '1 : ((64'h1 << w) - 64'h1);
      for (int unsigned k = 0; k < w; k++) begin
         b = lsb ? pattern[k] : pattern[w-1-k];
         if (lsb) begin
            fb = st[0] ^ b;
            st = st >> 1;
         end else begin
            fb = st[w-1] ^ b;
            st = (st << 1) & mask;
         end
         if (fb) st = st ^ poly;
      end
      return st;
   endfunction

endpackage

// File: rtl/crc_step_core.sv
module crc_step_core #(
   parameter int unsigned          WIDTH     = 16,
   parameter logic [WIDTH-1:0]     POLY      = 16'h1021,
   parameter bit                   LSB_FIRST = 1'b0
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             din,
   output logic [WIDTH-1:0] nxt
);

   logic fb;

   if (LSB_FIRST) begin : g_lsb
      assign fb  = cur[0] ^ din;
      assign nxt = {1'b0, cur[WIDTH-1:1]} ^ ({WIDTH{fb}} & POLY);
   end else begin : g_msb
      assign fb  = cur[WIDTH-1] ^ din;
      assign nxt = {cur[WIDTH-2:0], 1'b0} ^ ({WIDTH{fb}} & POLY);
   end

endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
   parameter int unsigned      WIDTH     = 16,
   parameter logic [WIDTH-1:0] PRESET    = {WIDTH{1'b1}},
   parameter bit               LSB_FIRST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             sop,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic [WIDTH-1:0] stepped,
   output logic [WIDTH-1:0] base,
   output logic [WIDTH-1:0] state
);

   // Start of message makes the step operate on the preset value.
   assign base = sop ? PRESET : state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state <= PRESET;
      else if (clr)     state <= PRESET;
      else if (bit_vld) state <= stepped;
      else if (sop)     state <= PRESET;
   end

   // R3
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !sop && !bit_vld) |=> $stable(state));

   // R5
   clear_loads_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (state == PRESET));

   // R4
   start_loads_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sop && !clr && !bit_vld) |=> (state == PRESET));

   if (LSB_FIRST) begin : g_chk_lsb
      // R2
      lsb_plain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_vld && !clr && !sop && (state[0] == bit_in))
         |=> (state == {1'b0, $past(state[WIDTH-1:1])}));
   end else begin : g_chk_msb
      // R1
      msb_plain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_vld && !clr && !sop && (state[WIDTH-1] == bit_in))
         |=> (state == {$past(state[WIDTH-2:0]), 1'b0}));
   end

endmodule

// File: rtl/crc_out_stage.sv
module crc_out_stage #(
   parameter int unsigned      WIDTH   = 16,
   parameter logic [WIDTH-1:0] XOR_OUT = {WIDTH{1'b1}},
   parameter logic [WIDTH-1:0] RESIDUE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] state,
   output logic [WIDTH-1:0] crc_out,
   output logic             crc_pass
);

   assign crc_out  = state ^ XOR_OUT;
   assign crc_pass = (state == RESIDUE);

   // R8
   pass_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crc_pass |-> (crc_out == (RESIDUE ^ XOR_OUT)));

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
   parameter int unsigned      WIDTH     = 16,
   parameter logic [WIDTH-1:0] POLY      = 16'h1021,
   parameter bit               LSB_FIRST = 1'b0,
   parameter logic [WIDTH-1:0] PRESET    = {WIDTH{1'b1}},
   parameter logic [WIDTH-1:0] XOR_OUT   = {WIDTH{1'b1}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             sop,
   input  logic             bit_vld,
   input  logic             bit_in,
   output logic [WIDTH-1:0] crc_out,
   output logic             crc_pass
);

   localparam logic [crc_pkg::MAX_WIDTH-1:0] RES_FULL =
      crc_pkg::crc_residue(WIDTH, 64'(POLY), LSB_FIRST, 64'(XOR_OUT));
   localparam logic [WIDTH-1:0] RESIDUE = RES_FULL[WIDTH-1:0];
   localparam int unsigned CONST_TAP = LSB_FIRST ? WIDTH - 1 : 0;

   if (WIDTH < 2 || WIDTH > crc_pkg::MAX_WIDTH) begin : g_bad_width
      $error("crc_serial_engine: WIDTH must lie in 2..64");
   end
   if (POLY[CONST_TAP] != 1'b1) begin : g_bad_poly
      $error("crc_serial_engine: POLY lacks the constant term for this shift direction");
   end

   logic [WIDTH-1:0] base;
   logic [WIDTH-1:0] stepped;
   logic [WIDTH-1:0] state;

   crc_step_core #(
      .WIDTH     (WIDTH),
      .POLY      (POLY),
      .LSB_FIRST (LSB_FIRST)
   ) step_i (
      .cur (base),
      .din (bit_in),
      .nxt (stepped)
   );

   crc_state_reg #(
      .WIDTH     (WIDTH),
      .PRESET    (PRESET),
      .LSB_FIRST (LSB_FIRST)
   ) reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .sop     (sop),
      .bit_vld (bit_vld),
      .bit_in  (bit_in),
      .stepped (stepped),
      .base    (base),
      .state   (state)
   );

   crc_out_stage #(
      .WIDTH   (WIDTH),
      .XOR_OUT (XOR_OUT),
      .RESIDUE (RESIDUE)
   ) out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .crc_out  (crc_out),
      .crc_pass (crc_pass)
   );

endmodule

// File: tb/crc_serial_engine_tb.sv
module crc_serial_engine_tb_top;

   localparam int          CW    [4] = '{16, 8, 8, 16};
   localparam logic [31:0] CPOLY [4] = '{32'h1021, 32'h07, 32'hE0, 32'h8408};
   localparam bit          CLSB  [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
   localparam logic [31:0] CPRE  [4] = '{32'hFFFF, 32'h0, 32'h0, 32'hFFFF};
   localparam logic [31:0] CXO   [4] = '{32'h0, 32'h0, 32'h0, 32'hFFFF};
   localparam logic [31:0] CRES  [4] = '{32'h0, 32'h0, 32'h0, 32'hF0B8};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        sop = 1'b0;
   logic [3:0]  vld = '0;
   logic [3:0]  sbit = '0;
   logic [15:0] o0, o3;
   logic [7:0]  o1, o2;
   logic [3:0]  pass;
   logic [31:0] m_st [4];
   logic [7:0]  msg [0:63];
   int          checks = 0;
   int          failures = 0;

   always #4 clk = ~clk;

   crc_serial_engine #(.WIDTH(16), .POLY(16'h1021), .LSB_FIRST(1'b0),
      .PRESET(16'hFFFF), .XOR_OUT(16'h0)) dut_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .sop(sop), .bit_vld(vld[0]),
      .bit_in(sbit[0]), .crc_out(o0), .crc_pass(pass[0]));
   crc_serial_engine #(.WIDTH(8), .POLY(8'h07), .LSB_FIRST(1'b0),
      .PRESET(8'h00), .XOR_OUT(8'h00)) dut_c8m_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .sop(sop), .bit_vld(vld[1]),
      .bit_in(sbit[1]), .crc_out(o1), .crc_pass(pass[1]));
   crc_serial_engine #(.WIDTH(8), .POLY(8'hE0), .LSB_FIRST(1'b1),
      .PRESET(8'h00), .XOR_OUT(8'h00)) dut_c8l_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .sop(sop), .bit_vld(vld[2]),
      .bit_in(sbit[2]), .crc_out(o2), .crc_pass(pass[2]));
   crc_serial_engine #(.WIDTH(16), .POLY(16'h8408), .LSB_FIRST(1'b1),
      .PRESET(16'hFFFF), .XOR_OUT(16'hFFFF)) dut_inv_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .sop(sop), .bit_vld(vld[3]),
      .bit_in(sbit[3]), .crc_out(o3), .crc_pass(pass[3]));

   function automatic logic [31:0] got(input int d);
      case (d)
         0: return {16'h0, o0};
         1: return {24'h0, o1};
         2: return {24'h0, o2};
         default: return {16'h0, o3};
      endcase
   endfunction

   function automatic logic [31:0] mdl_step(input logic [31:0] st, input logic b,
                                            input int w, input logic [31:0] poly,
                                            input bit lsb);
      logic [31:0] mask;
      logic fb;
      mask = (32'h1 << w) - 32'h1;
      if (lsb) begin
         fb = st[0] ^ b;
         st = st >> 1;
      end else begin
         fb = st[w-1] ^ b;
         st = (st << 1) & mask;
      end
      if (fb) st = st ^ poly;
      return st;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] v, input logic [3:0] b,
                        input logic s, input logic c);
      @(negedge clk);
      vld = v; sbit = b; sop = s; clr = c;
      @(posedge clk);
      for (int d = 0; d < 4; d++) begin
         if (c) m_st[d] = CPRE[d];
         else if (v[d]) m_st[d] = mdl_step(s ? CPRE[d] : m_st[d], b[d], CW[d], CPOLY[d], CLSB[d]);
         else if (s) m_st[d] = CPRE[d];
      end
      #1;
      vld = '0; sbit = '0; sop = 1'b0; clr = 1'b0;
   endtask

   // Compares every instance against the bench model (R1 R2 R7 R8).
   task automatic check_all(input string what);
      @(negedge clk);
      for (int d = 0; d < 4; d++) begin
         chk(got(d) == (m_st[d] ^ CXO[d]), CLSB[d] ? "R2" : "R1", what,
             got(d), m_st[d] ^ CXO[d]);
         chk(pass[d] == (m_st[d] == CRES[d]), "R8", what, {31'h0, pass[d]},
             {31'h0, m_st[d] == CRES[d]});
      end
   endtask

   task automatic send_msg(input int len);
      logic [3:0] b;
      for (int i = 0; i < len; i++) begin
         for (int k = 0; k < 8; k++) begin
            for (int d = 0; d < 4; d++) b[d] = CLSB[d] ? msg[i][k] : msg[i][7-k];
            drive(4'hF, b, (i == 0) && (k == 0), 1'b0);
         end
      end
   endtask

   task automatic append_crc(input bit corrupt);
      logic [31:0] tx [4];
      logic [3:0] v, b;
      for (int d = 0; d < 4; d++) tx[d] = m_st[d] ^ CXO[d];
      for (int k = 0; k < 16; k++) begin
         for (int d = 0; d < 4; d++) begin
            v[d] = k < CW[d];
            b[d] = (k >= CW[d]) ? 1'b0 : (CLSB[d] ? tx[d][k] : tx[d][CW[d]-1-k]);
            if (corrupt && k == 3) b[d] = ~b[d];
         end
         drive(v, b, 1'b0, 1'b0);
      end
      @(negedge clk);
      for (int d = 0; d < 4; d++)
         chk(pass[d] == !corrupt, "R8", corrupt ? "corrupted append" : "good append",
             {31'h0, pass[d]}, {31'h0, !corrupt});
   endtask

   task automatic load_digits();
      for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] hold [4];
      void'($urandom(32'd5171));
      for (int d = 0; d < 4; d++) m_st[d] = CPRE[d];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R6: reset state
      @(negedge clk);
      for (int d = 0; d < 4; d++)
         chk(got(d) == (CPRE[d] ^ CXO[d]), "R6", "reset value", got(d), CPRE[d] ^ CXO[d]);
      check_all("after reset");

      // R1 R2: single byte 0x57 on the 8-bit instances
      msg[0] = 8'h57;
      send_msg(1);
      check_all("byte 0x57");
      chk(o1 == 8'hA2, "R1", "0x57 msb-first", {24'h0, o1}, 32'hA2);
      chk(o2 == 8'h19, "R2", "0x57 lsb-first", {24'h0, o2}, 32'h19);
      append_crc(1'b0);

      // R4: junk then restart mid-message; R9 R2 R7 known string values
      msg[0] = 8'hC3; msg[1] = 8'h5A;
      send_msg(2);
      load_digits();
      send_msg(9);
      check_all("digits");
      chk(o0 == 16'h29B1, "R9", "digits 0x1021", {16'h0, o0}, 32'h29B1);
      chk(o3 == 16'h906E, "R2", "digits 0x8408 inverted (R7)", {16'h0, o3}, 32'h906E);
      chk(o0 == 16'h29B1, "R4", "restart discards earlier bits", {16'h0, o0}, 32'h29B1);
      append_crc(1'b0);
      chk(o3 == 16'h0F47, "R8", "inverted residue on output", {16'h0, o3}, 32'h0F47);
      chk(o0 == 16'h0000, "R8", "zero residue", {16'h0, o0}, 32'h0);

      // R8: corrupted check value
      send_msg(9);
      append_crc(1'b1);

      // R3: idle cycles with a toggling bit
      msg[0] = 8'h9E; msg[1] = 8'h21;
      send_msg(2);
      @(negedge clk);
      for (int d = 0; d < 4; d++) hold[d] = got(d);
      for (int i = 0; i < 6; i++) drive(4'h0, 4'($urandom), 1'b0, 1'b0);
      @(negedge clk);
      for (int d = 0; d < 4; d++) chk(got(d) == hold[d], "R3", "idle hold", got(d), hold[d]);

      // R5: clear beats sop and a valid bit
      drive(4'hF, 4'hF, 1'b1, 1'b1);
      @(negedge clk);
      for (int d = 0; d < 4; d++)
         chk(got(d) == (CPRE[d] ^ CXO[d]), "R5", "clear priority", got(d), CPRE[d] ^ CXO[d]);

      // Random messages with one-pass checks
      for (int n = 0; n < 40; n++) begin
         int len;
         len = 1 + int'($urandom % 12);
         for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
         send_msg(len);
         check_all("random message");
         append_crc(($urandom % 4) == 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule